// File: doc/BRIEF.md
# Masked Interrupt Controller with Sleep Wake-Up

This block collects interrupt requests for a small 8-bit processor core and decides when the core must leave its instruction stream for a fixed handler address. It watches five request lines: a timer overflow pulse, a change on an 8-bit input port, two external pins, and a change of a comparator output. Each request is recorded in a flag bit, but only if the matching mask bit is on. The global enable does not affect this recording; it only decides whether the core is sent to the handler.

Software reaches four 8-bit registers through a small select/write/read interface. Two hold flags and two hold masks. A read of a flag register returns the flags ANDed with their masks. Three single-cycle strobes from the core control the global enable: an enable strobe, a disable strobe and a return-from-handler strobe. The enable is cleared by itself when the handler is entered, so the handler is not entered again while it runs.

Port-change detection compares the live port against a copy taken the last time software read the port. While the core sleeps, an unmasked port-change flag raises a wake-up output, whatever the global enable state. The external pins pass through a digital glitch filter and an edge detector whose polarity is a parameter for each pin.

Top module: `irq_ctl`

## Requirements
- R1: After reset, all flags, all masks and the global enable read as 0, and `vec_go` and `wake` are low.
- R2: A request sets its flag bit at the next clock edge when its mask bit is 1, whatever the global enable state. A request whose mask bit is 0 leaves the flag bit at 0, and turning on the mask later does not show it.
- R3: Register map on `reg_sel`: 0 = flag register A, 1 = flag register B, 2 = mask register A, 3 = mask register B. A read of 0 or 1 returns flag AND mask. A read of 2 or 3 returns the mask. Register A bits: 0 timer, 1 port change, 2 external pin 0, 3 external pin 1. Register B bit 0 is the comparator change.
- R4: When the global enable is 1 and any flag AND mask bit is 1 at a clock edge, `vec_go` is high for exactly one cycle after that edge. The global enable is 0 after that same edge. `vec_addr` is the constant 0x008.
- R5: `en_stb` sets the global enable and `dis_stb` clears it. `dis_stb` wins when both arrive in the same cycle.
- R6: A flag stays set until software writes it to 0. `reti_stb` sets the global enable again, and a flag that is still set then causes another vector.
- R7: The port-change flag is set when any port pin differs from the reference. The reference is captured from the port on each cycle with `port_rd` high.
- R8: `wake` = `sleep_i` AND the port-change flag AND its mask, with no dependence on the global enable. With the global enable at 0 there is no vector.
- R9: The comparator flag is set on either edge of the comparator input, two clock edges after it changes.
- R10: An external pin level is accepted only after FILT_CYC consecutive equal samples. A pulse shorter than that sets no flag.
- R11: External pin 0 requests on a rising filtered level and pin 1 on a falling one (default EXT_RISE = 2'b01). The opposite edge is ignored.
- R12: A software write to a flag register takes priority over any hardware set of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf | input | 1 | Timer overflow request pulse |
| port_in | input | PORT_W | Watched input port |
| port_rd | input | 1 | Port is being read; capture reference |
| ext_pin | input | 2 | External request pins |
| cmp_in | input | 1 | Comparator output |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (flags masked) |
| en_stb | input | 1 | Global enable set strobe |
| dis_stb | input | 1 | Global enable clear strobe |
| reti_stb | input | 1 | Return-from-handler strobe |
| sleep_i | input | 1 | Core is sleeping |
| int_en | output | 1 | Global enable state |
| vec_go | output | 1 | One-cycle vector request |
| vec_addr | output | PC_W | Handler address |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume that the core's strobes are single-cycle, synchronous pulses, and that a flag-register write is the only software path to the flag state. The return-from-handler check also assumes that no disable strobe arrives in the same cycle. The stimulus changes every input just after the falling clock edge and never raises `dis_stb` together with `reti_stb`. It also keeps the port and the comparator still during each read-back, so that the value sampled after a rising edge is the settled state.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;
   typedef enum logic [1:0] {
      SEL_FLAG_A = 2'd0,
      SEL_FLAG_B = 2'd1,
      SEL_MASK_A = 2'd2,
      SEL_MASK_B = 2'd3
   } reg_sel_e;

   // bit positions inside register A
   localparam int BIT_TMR  = 0;
   localparam int BIT_PCHG = 1;
   localparam int BIT_EXT0 = 2;
   localparam int BIT_EXT1 = 3;
   // bit position inside register B
   localparam int BIT_CMP  = 0;
endpackage

// File: rtl/irq_ext_pin.sv
`timescale 1ns/1ps
// Glitch filter and edge detector for one external request pin.
module irq_ext_pin #(
   parameter int   FILT_CYC = 4,
   parameter logic RISE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic hit
);
   localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC + 1) : 1;

   logic raw_q;
   logic lvl;
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= pin;
   end

   generate
      if (FILT_CYC <= 1) begin : g_nofilt
         assign lvl = raw_q;
      end else begin : g_filt
         logic [CW-1:0] cnt;
         logic          lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               lvl_q <= 1'b0;
            end else if (raw_q == lvl_q) begin
               cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
               lvl_q <= raw_q;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign lvl = lvl_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   generate
      if (RISE) begin : g_rise
         assign hit = lvl & ~lvl_d;
      end else begin : g_fall
         assign hit = ~lvl & lvl_d;
      end
   endgenerate
endmodule

// File: rtl/irq_port_watch.sv
`timescale 1ns/1ps
// Compares the live port against the value captured at the last port read.
module irq_port_watch #(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_in,
   input  logic              port_rd,
   output logic              changed
);
   logic [PORT_W-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ref_q <= '0;
      else if (port_rd) ref_q <= port_in;
   end

   assign changed = |(port_in ^ ref_q);
endmodule

// File: rtl/irq_cmp_watch.sv
`timescale 1ns/1ps
// Registers the comparator output and flags either transition.
module irq_cmp_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_in,
   output logic toggled
);
   logic cmp_q;
   logic cmp_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= 1'b0;
         cmp_d <= 1'b0;
      end else begin
         cmp_q <= cmp_in;
         cmp_d <= cmp_q;
      end
   end

   assign toggled = cmp_q ^ cmp_d;
endmodule

// File: rtl/irq_ctl.sv
`timescale 1ns/1ps
module irq_ctl
   import irq_ctl_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter int         PORT_W   = 8,
   parameter int         PC_W     = 10,
   parameter int         VEC_ADDR = 8,
   parameter int         FILT_CYC = 4,
   parameter logic [1:0] EXT_RISE = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_ovf,
   input  logic [PORT_W-1:0] port_in,
   input  logic              port_rd,
   input  logic [1:0]        ext_pin,
   input  logic              cmp_in,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              en_stb,
   input  logic              dis_stb,
   input  logic              reti_stb,
   input  logic              sleep_i,
   output logic              int_en,
   output logic              vec_go,
   output logic [PC_W-1:0]   vec_addr,
   output logic              wake
);
   localparam int NUM_EXT = 2;

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("irq_ctl: DATA_W must be at least 4");
      end
      if (PORT_W < 1) begin : g_bad_port
         $error("irq_ctl: PORT_W must be at least 1");
      end
      if (VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
         $error("irq_ctl: VEC_ADDR does not fit in PC_W");
      end
      if (FILT_CYC < 0) begin : g_bad_filt
         $error("irq_ctl: FILT_CYC must not be negative");
      end
   endgenerate

   logic [NUM_EXT-1:0] ext_hit;
   logic               port_chg;
   logic               cmp_chg;

   for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      irq_ext_pin #(
         .FILT_CYC (FILT_CYC),
         .RISE     (EXT_RISE[g])
      ) u_pin (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (ext_pin[g]),
         .hit   (ext_hit[g])
      );
   end

   irq_port_watch #(.PORT_W(PORT_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_in (port_in),
      .port_rd (port_rd),
      .changed (port_chg)
   );

   irq_cmp_watch u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_in  (cmp_in),
      .toggled (cmp_chg)
   );

   // request vectors aligned with the register bit map
   logic [DATA_W-1:0] set_a;
   logic [DATA_W-1:0] set_b;

   always_comb begin
      set_a           = '0;
      set_a[BIT_TMR]  = tmr_ovf;
      set_a[BIT_PCHG] = port_chg;
      set_a[BIT_EXT0] = ext_hit[0];
      set_a[BIT_EXT1] = ext_hit[1];
      set_b           = '0;
      set_b[BIT_CMP]  = cmp_chg;
   end

   logic [DATA_W-1:0] flag_a, flag_b, mask_a, mask_b;
   logic              wr_fa, wr_fb, wr_ma, wr_mb;

   assign wr_fa = reg_wr && (reg_sel == SEL_FLAG_A);
   assign wr_fb = reg_wr && (reg_sel == SEL_FLAG_B);
   assign wr_ma = reg_wr && (reg_sel == SEL_MASK_A);
   assign wr_mb = reg_wr && (reg_sel == SEL_MASK_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_a <= '0;
         flag_b <= '0;
         mask_a <= '0;
         mask_b <= '0;
      end else begin
         flag_a <= wr_fa ? reg_wdata : (flag_a | (set_a & mask_a));
         flag_b <= wr_fb ? reg_wdata : (flag_b | (set_b & mask_b));
         if (wr_ma) mask_a <= reg_wdata;
         if (wr_mb) mask_b <= reg_wdata;
      end
   end

   logic [DATA_W-1:0] live_a, live_b;
   logic              pending;
   logic              take;
   logic              gie_q;
   logic              go_q;

   assign live_a  = flag_a & mask_a;
   assign live_b  = flag_b & mask_b;
   assign pending = (|live_a) | (|live_b);
   assign take    = gie_q & pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         go_q <= take;
         if (dis_stb || take)        gie_q <= 1'b0;
         else if (en_stb || reti_stb) gie_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (reg_sel)
         SEL_FLAG_A: reg_rdata = live_a;
         SEL_FLAG_B: reg_rdata = live_b;
         SEL_MASK_A: reg_rdata = mask_a;
         default:    reg_rdata = mask_b;
      endcase
   end

   assign int_en   = gie_q;
   assign vec_go   = go_q;
   assign vec_addr = PC_W'(VEC_ADDR);
   assign wake     = sleep_i & live_a[BIT_PCHG];
endmodule

// File: rtl/irq_ctl_chk.sv
`timescale 1ns/1ps
module irq_ctl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_stb,
   input logic              dis_stb,
   input logic              reti_stb,
   input logic              sleep_i,
   input logic              int_en,
   input logic              vec_go,
   input logic              wake,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] flag_a
);
   AST_VEC_FROM_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_go |-> $past(int_en)); // R4
   AST_VEC_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_go |-> !int_en); // R4
   AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_go |=> !vec_go); // R4
   AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb |=> !int_en); // R5
   AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_stb && !dis_stb && !int_en) |=> int_en); // R5
   AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_stb && !dis_stb && !int_en) |=> int_en); // R6
   AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> sleep_i); // R8
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd0) |=> (flag_a == $past(reg_wdata))); // R12
endmodule

bind irq_ctl irq_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_stb    (en_stb),
   .dis_stb   (dis_stb),
   .reti_stb  (reti_stb),
   .sleep_i   (sleep_i),
   .int_en    (int_en),
   .vec_go    (vec_go),
   .wake      (wake),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .flag_a    (flag_a)
);

// File: tb/irq_ctl_test.sv
`timescale 1ns/1ps
module irq_ctl_test;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmr_ovf = 0, port_rd = 0, cmp_in = 0, reg_wr = 0;
   logic          en_stb = 0, dis_stb = 0, reti_stb = 0, sleep_i = 0;
   logic [7:0]    port_in = 8'h00;
   logic [1:0]    ext_pin = 2'b00;
   logic [1:0]    reg_sel = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          int_en, vec_go, wake;
   logic [9:0]    vec_addr;

   irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .port_in(port_in),
      .port_rd(port_rd), .ext_pin(ext_pin), .cmp_in(cmp_in),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .en_stb(en_stb), .dis_stb(dis_stb),
      .reti_stb(reti_stb), .sleep_i(sleep_i), .int_en(int_en),
      .vec_go(vec_go), .vec_addr(vec_addr), .wake(wake)
   );

   always #2 clk = ~clk;

   // kinds: 0 reg_rdata, 1 vec_go, 2 int_en, 3 wake
   typedef struct {
      int       kind;
      logic [7:0] exp;
      string    tag;
   } item_t;

   item_t exp_q[$];
   int    n_run = 0;
   int    n_fail = 0;
   int    cycles = 0;

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic expect_after_edge(int kind, logic [7:0] exp, string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      exp_q.push_back(it);
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] val);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
      cyc();
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [1:0] sel, logic [7:0] exp, string tag);
      reg_sel = sel;
      expect_after_edge(0, exp, tag);
      cyc();
   endtask

   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   // monitor: compares queued expectations right after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cycles++;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            case (it.kind)
               0:       act = reg_rdata;
               1:       act = {7'd0, vec_go};
               2:       act = {7'd0, int_en};
               default: act = {7'd0, wake};
            endcase
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      wait (cycles >= 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      rd_chk(2'd0, 8'h00, "R1 flag A");
      rd_chk(2'd2, 8'h00, "R1 mask A");
      expect_after_edge(2, 0, "R1 int_en");
      expect_after_edge(1, 0, "R1 vec_go");
      expect_after_edge(3, 0, "R1 wake");
      cyc();
      n_run++;
      if (vec_addr !== 10'h008) begin
         n_fail++;
         $display("FAIL R4 vec_addr: actual %h expected %h", vec_addr, 10'h008);
      end

      // R2 masked-off request is dropped
      tmr_ovf = 1; cyc(); tmr_ovf = 0;
      wr(2'd2, 8'h01);
      rd_chk(2'd0, 8'h00, "R2 masked request ignored");
      // R2 flag set with global enable off
      tmr_ovf = 1; reg_sel = 2'd0;
      expect_after_edge(0, 8'h01, "R2 flag set while disabled");
      cyc(); tmr_ovf = 0;
      expect_after_edge(1, 0, "R2 no vector while disabled");
      cyc();

      // R3 readback is flag AND mask
      wr(2'd2, 8'h00);
      rd_chk(2'd0, 8'h00, "R3 masked readback");
      wr(2'd2, 8'h01);
      rd_chk(2'd0, 8'h01, "R3 flag retained");
      rd_chk(2'd2, 8'h01, "R3 mask readback");

      // R4 / R5 vector on enable
      en_stb = 1;
      expect_after_edge(2, 1, "R5 enable strobe");
      cyc(); en_stb = 0;
      expect_after_edge(1, 1, "R4 vector");
      expect_after_edge(2, 0, "R4 enable cleared on vector");
      cyc();
      expect_after_edge(1, 0, "R4 single pulse");
      cyc();

      // R6 return re-enables and re-vectors while flag stays set
      reti_stb = 1;
      expect_after_edge(2, 1, "R6 return sets enable");
      cyc(); reti_stb = 0;
      expect_after_edge(1, 1, "R6 re-vector");
      cyc();
      wr(2'd0, 8'h00);
      reti_stb = 1; cyc(); reti_stb = 0;
      expect_after_edge(1, 0, "R6 no vector once cleared");
      expect_after_edge(2, 1, "R6 enable held");
      cyc();

      // R5 disable, and disable wins over enable
      dis_stb = 1;
      expect_after_edge(2, 0, "R5 disable strobe");
      cyc();
      en_stb = 1;
      expect_after_edge(2, 0, "R5 disable wins");
      cyc(); en_stb = 0; dis_stb = 0;

      // R12 write beats hardware set
      reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h00; tmr_ovf = 1;
      cyc(); reg_wr = 0; tmr_ovf = 0;
      rd_chk(2'd0, 8'h00, "R12 write priority");
      tmr_ovf = 1; cyc(); tmr_ovf = 0;
      rd_chk(2'd0, 8'h01, "R12 set without write");
      wr(2'd0, 8'h00);

      // R7 port change against read reference
      port_in = 8'h5A; port_rd = 1; cyc(); port_rd = 0; cyc();
      wr(2'd2, 8'h02);
      rd_chk(2'd0, 8'h00, "R7 no change after read");
      port_in = 8'h5B; cyc();
      rd_chk(2'd0, 8'h02, "R7 pin change sets flag");

      // R8 wake-up independent of global enable
      sleep_i = 1;
      expect_after_edge(3, 1, "R8 wake in sleep");
      expect_after_edge(1, 0, "R8 no vector when disabled");
      cyc();
      sleep_i = 0;
      expect_after_edge(3, 0, "R8 no wake when awake");
      cyc();
      port_rd = 1; cyc(); port_rd = 0;
      wr(2'd0, 8'h00);
      cyc();
      rd_chk(2'd0, 8'h00, "R7 re-armed by read");

      // R9 comparator either edge
      wr(2'd3, 8'h01);
      cmp_in = 1; wait_n(4);
      rd_chk(2'd1, 8'h01, "R9 rising change");
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h00, "R9 cleared");
      cmp_in = 0; wait_n(4);
      rd_chk(2'd1, 8'h01, "R9 falling change");
      wr(2'd1, 8'h00);

      // R10 / R11 external pins
      wr(2'd2, 8'h0C);
      ext_pin[0] = 1; wait_n(2); ext_pin[0] = 0; wait_n(10);
      rd_chk(2'd0, 8'h00, "R10 short pulse rejected");
      ext_pin[0] = 1; wait_n(10);
      rd_chk(2'd0, 8'h04, "R10 held level accepted");
      wr(2'd0, 8'h00);
      ext_pin[0] = 0; wait_n(10);
      rd_chk(2'd0, 8'h00, "R11 pin0 falling ignored");
      ext_pin[1] = 1; wait_n(10);
      rd_chk(2'd0, 8'h00, "R11 pin1 rising ignored");
      ext_pin[1] = 0; wait_n(10);
      rd_chk(2'd0, 8'h08, "R11 pin1 falling accepted");

      wait_n(2);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule